// File: doc/BRIEF.md
# Receive DMA Ring Commit Manager

This block sits between a receive frame source and a circular receive buffer in host memory. Incoming frames arrive as a stream of 16-bit words. The block turns them into byte-offset writes into a ring whose size is 16 KB or 64 KB, selected by an input pin. Every frame starts on a 4-byte boundary. This leaves an unused gap of 1, 2 or 3 bytes after a frame whose length is not a multiple of four. The block records where the most recently completed frame starts and counts completed frames. It also raises a frame-pending flag that the host polls.

Buffer space is protected by an explicit handshake with the host. When the host reads the frame counter, it takes ownership of every frame counted by that read, and that region of the ring becomes committed. The committed region is released by any of three events:

- the next counter read;
- a buffer-event read that finds the pending flag set, because new frames have arrived since the commit;
- a reset-DMA command, given as bit 6 of a bus-control write.

A word that would land inside committed space is never written. The frame that carried it is dropped and a sticky overflow flag is raised.

Top module: `rxring_commit_mgr`

## Requirements
- R1: After reset the frame count is 0, the pending flag and the overflow flag are low, the start-of-frame offset is 0 and no write is issued.
- R2: Each accepted word is written in the cycle its strobe is high. Successive words of a frame use byte offsets 2 apart, starting at the frame start. Offsets wrap modulo 16384 when `buf_large` is 0 and modulo 65536 when it is 1.
- R3: A frame of L bytes that starts at offset S makes the next frame start at (S+L) rounded up to a multiple of 4, modulo the ring size. The start-of-frame output shows S once the frame ends.
- R4: Each frame that ends without being dropped adds one to the frame count. A host read with select 1 (count) returns the count and sets it to 0.
- R5: A count read commits the ring span from the end of the frames committed by the previous read to the end of the last frame it counted. While that span is committed, a word addressed inside it is not written, the rest of its frame is discarded, the frame is not counted, and the overflow flag is set and stays set.
- R6: A count read releases the span committed by the previous count read, even when it returns 0.
- R7: A host read with select 2 (buffer event) that sees the pending flag set releases the committed span.
- R8: A bus-control write with data bit 6 set clears, by the next clock: the count, the pending flag, the overflow flag, the start-of-frame offset, the commit and the write position (to 0). A write with bit 6 clear changes none of these.
- R9: With `stream_mode` low, the pending flag rises in the cycle after the count goes from 0 to non-zero. In both modes it is low whenever the count is 0. A buffer-event read never clears it.
- R10: With `stream_mode` high, frames alone do not raise the pending flag. It rises after a `strm_done` pulse while the count is non-zero.
- R11: A buffer-event read returns the pending flag in data bit 7 with all other bits 0. A host read with select 3 (receive event) returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_large | input | 1 | Ring size: 0 = 16 KB, 1 = 64 KB |
| stream_mode | input | 1 | Selects the stream rule for the pending flag |
| fr_start | input | 1 | Start-of-frame pulse |
| wd_valid | input | 1 | Word strobe |
| wd_data | input | 16 | Word data |
| fr_end | input | 1 | End-of-frame pulse |
| fr_len | input | 16 | Frame length in bytes, valid with `fr_end` |
| strm_done | input | 1 | End of a stream transfer cycle |
| host_rd | input | 1 | Host register read strobe |
| host_rd_sel | input | 2 | 1 = count, 2 = buffer event, 3 = receive event |
| host_rdata | output | 16 | Read data for the selected register |
| host_wr_busctl | input | 1 | Bus-control write strobe |
| host_wdata | input | 16 | Bus-control write data (bit 6 = reset DMA) |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | 16 | Buffer byte offset |
| wr_data | output | 16 | Buffer write data |
| sof_offset | output | 16 | Start offset of the most recently completed frame |
| frame_count | output | 16 | Frames counted since the last count read |
| frame_pending | output | 1 | Frame-pending flag |
| overflow | output | 1 | Sticky flag: a frame was dropped against committed space |

## Verification
The assertions check the following on every cycle:
- consecutive writes step by two bytes within the selected ring;
- the pending flag is never high with a zero count, and survives a buffer-event read;
- in stream mode the pending flag does not rise without `strm_done`;
- the overflow flag rises only on a refused word and then stays set;
- an implied skip drops the commit;
- a reset-DMA write clears the visible state one clock later;
- receive-event reads return zero.

Only the directed scenarios can show the commit span itself at work. They fill the ring until the pointer wraps into committed space and confirm the refusal. They then confirm that a second count read, or an implied skip, lets the same offsets be written again. The scenarios also show the exact hole sizes after frames of odd lengths, and that the wrap point follows `buf_large`.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   typedef enum logic [1:0] {
      RD_NONE   = 2'd0,
      RD_FCOUNT = 2'd1,
      RD_BUFEVT = 2'd2,
      RD_RXEVT  = 2'd3
   } rd_sel_e;

   localparam int BUSCTL_RSTDMA_BIT = 6;
   localparam int BUFEVT_PEND_BIT   = 7;

   // Offset a lies in the ring span [b, e); b == e means the whole ring.
   function automatic logic ofs_in_span(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] e);
      if (b < e)       return (a >= b) && (a < e);
      else if (b > e)  return (a >= b) || (a < e);
      else             return 1'b1;
   endfunction

endpackage

// File: rtl/rxring_wrptr.sv
module rxring_wrptr #(
   parameter int OFS_W    = 16,
   parameter int LEN_W    = 16,
   parameter int SMALL_AW = 14,
   parameter int ALIGN_B  = 4,
   parameter int WORD_B   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_large,
   input  logic             rst_dma,
   input  logic             fr_start,
   input  logic             wd_valid,
   input  logic             fr_end,
   input  logic [LEN_W-1:0] fr_len,
   input  logic             blocked,
   output logic [OFS_W-1:0] cur_addr,
   output logic             wr_en,
   output logic             drop_evt,
   output logic             frame_done,
   output logic [OFS_W-1:0] sof_q,
   output logic [OFS_W-1:0] done_ptr,
   output logic [OFS_W-1:0] ring_mask
);

   localparam int SUM_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;
   localparam logic [OFS_W-1:0] ALIGN_M = OFS_W'(ALIGN_B - 1);
   localparam logic [OFS_W-1:0] STEP    = OFS_W'(WORD_B);

   if ((ALIGN_B & (ALIGN_B - 1)) != 0 || ALIGN_B < WORD_B) begin : g_bad_align
      $error("rxring_wrptr: ALIGN_B must be a power of two not below WORD_B");
   end

   // Ring-size variants: one fixed size, or a choice of two.
   if (SMALL_AW >= OFS_W) begin : g_one_size
      assign ring_mask = '1;
   end else begin : g_two_sizes
      localparam logic [OFS_W-1:0] SMALL_M = {OFS_W{1'b1}} >> (OFS_W - SMALL_AW);
      assign ring_mask = buf_large ? {OFS_W{1'b1}} : SMALL_M;
   end

   logic             active_q;
   logic             drop_q;
   logic [OFS_W-1:0] fstart_q;
   logic [SUM_W-1:0] end_raw;
   logic [OFS_W-1:0] end_al;
   logic             word_try;

   assign word_try   = active_q && !drop_q && wd_valid && !fr_start;
   assign wr_en      = word_try && !blocked;
   assign drop_evt   = word_try && blocked;
   assign frame_done = active_q && !drop_q && !drop_evt && fr_end && !fr_start;

   assign end_raw = SUM_W'(fstart_q) + SUM_W'(fr_len) + SUM_W'(ALIGN_M);
   assign end_al  = OFS_W'(end_raw) & ~ALIGN_M & ring_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         drop_q   <= 1'b0;
         fstart_q <= '0;
         cur_addr <= '0;
         sof_q    <= '0;
         done_ptr <= '0;
      end else if (rst_dma) begin
         active_q <= 1'b0;
         drop_q   <= 1'b0;
         fstart_q <= '0;
         cur_addr <= '0;
         sof_q    <= '0;
         done_ptr <= '0;
      end else if (fr_start) begin
         active_q <= 1'b1;
         drop_q   <= 1'b0;
         fstart_q <= done_ptr;
         cur_addr <= done_ptr;
      end else begin
         if (wr_en)    cur_addr <= (cur_addr + STEP) & ring_mask;
         if (drop_evt) drop_q   <= 1'b1;
         if (fr_end)   active_q <= 1'b0;
         if (frame_done) begin
            sof_q    <= fstart_q;
            done_ptr <= end_al;
         end
      end
   end

   // R3: a completed frame publishes an aligned start offset
   assert_sof_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> ((sof_q & ALIGN_M) == '0));

endmodule

// File: rtl/rxring_commit.sv
module rxring_commit
   import rxring_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_dma,
   input  logic             cnt_rd,
   input  logic             cnt_nonzero,
   input  logic             skip_evt,
   input  logic             drop_evt,
   input  logic [OFS_W-1:0] done_ptr,
   input  logic [OFS_W-1:0] probe_addr,
   output logic             blocked,
   output logic             cmt_valid,
   output logic [OFS_W-1:0] cmt_base,
   output logic [OFS_W-1:0] cmt_end,
   output logic             overflow
);

   logic [OFS_W-1:0] mark_q;   // end of span handed over by the last count read

   assign blocked = cmt_valid &&
                    ofs_in_span(32'(probe_addr), 32'(cmt_base), 32'(cmt_end));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmt_valid <= 1'b0;
         cmt_base  <= '0;
         cmt_end   <= '0;
         mark_q    <= '0;
      end else if (rst_dma) begin
         cmt_valid <= 1'b0;
         cmt_base  <= '0;
         cmt_end   <= '0;
         mark_q    <= '0;
      end else if (cnt_rd) begin
         cmt_valid <= cnt_nonzero;
         cmt_base  <= mark_q;
         cmt_end   <= done_ptr;
         mark_q    <= done_ptr;
      end else if (skip_evt) begin
         cmt_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        overflow <= 1'b0;
      else if (rst_dma)  overflow <= 1'b0;
      else if (drop_evt) overflow <= 1'b1;
   end

   // R7: an implied skip drops the commit
   assert_skip_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_evt && !cnt_rd && !rst_dma) |=> !cmt_valid);

   // R5: the overflow flag only leaves the set state through reset-DMA
   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !rst_dma) |=> overflow);

endmodule

// File: rtl/rxring_evt.sv
module rxring_evt #(
   parameter int CNT_W   = 16,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_dma,
   input  logic             stream_mode,
   input  logic             strm_done,
   input  logic             frame_done,
   input  logic             cnt_rd,
   input  logic             bufevt_rd,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pend_q,
   output logic             cnt_nonzero,
   output logic             skip_evt
);

   logic [CNT_W-1:0] cnt_base;
   logic [CNT_W-1:0] cnt_next;
   logic             pend_next;
   logic             pend_rise;

   assign cnt_base    = cnt_rd ? '0 : cnt_q;
   assign cnt_nonzero = (cnt_q != '0);
   assign skip_evt    = bufevt_rd && pend_q;

   // Counter variants: hold at full scale, or wrap.
   if (SAT_CNT) begin : g_sat
      assign cnt_next = (frame_done && (cnt_base != '1)) ? cnt_base + 1'b1 : cnt_base;
   end else begin : g_wrap
      assign cnt_next = cnt_base + CNT_W'(frame_done);
   end

   assign pend_rise = stream_mode ? strm_done : (cnt_q == '0);

   always_comb begin
      if (cnt_next == '0) pend_next = 1'b0;
      else                pend_next = pend_q || pend_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (rst_dma) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_next;
         pend_q <= pend_next;
      end
   end

   // R9: pending never outlives an empty count
   assert_pend_needs_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q != '0));

   // R9: a buffer-event read leaves pending set
   assert_bufevt_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bufevt_rd && pend_q && !rst_dma && !cnt_rd) |=> pend_q);

   // R10: in stream mode pending needs the stream-done pulse to rise
   assert_stream_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_mode && !strm_done && !pend_q) |=> !pend_q);

endmodule

// File: rtl/rxring_commit_mgr.sv
module rxring_commit_mgr
   import rxring_pkg::*;
#(
   parameter int OFS_W    = 16,
   parameter int SMALL_AW = 14,
   parameter int LEN_W    = 16,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 16,
   parameter int ALIGN_B  = 4,
   parameter bit SAT_CNT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_large,
   input  logic              stream_mode,
   input  logic              fr_start,
   input  logic              wd_valid,
   input  logic [DATA_W-1:0] wd_data,
   input  logic              fr_end,
   input  logic [LEN_W-1:0]  fr_len,
   input  logic              strm_done,
   input  logic              host_rd,
   input  logic [1:0]        host_rd_sel,
   output logic [REG_W-1:0]  host_rdata,
   input  logic              host_wr_busctl,
   input  logic [REG_W-1:0]  host_wdata,
   output logic              wr_en,
   output logic [OFS_W-1:0]  wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [OFS_W-1:0]  sof_offset,
   output logic [CNT_W-1:0]  frame_count,
   output logic              frame_pending,
   output logic              overflow
);

   localparam int WORD_B = DATA_W / 8;

   if (CNT_W > REG_W || REG_W <= BUFEVT_PEND_BIT || REG_W <= BUSCTL_RSTDMA_BIT) begin : g_bad_reg
      $error("rxring_commit_mgr: register width too small for count or flag bits");
   end
   if (SMALL_AW > OFS_W || DATA_W % 16 != 0) begin : g_bad_geom
      $error("rxring_commit_mgr: ring or word geometry out of range");
   end

   rd_sel_e          rd_sel;
   logic             rst_dma;
   logic             cnt_rd;
   logic             bufevt_rd;
   logic             blocked;
   logic             drop_evt;
   logic             frame_done;
   logic             skip_evt;
   logic             cnt_nonzero;
   logic             cmt_valid;
   logic [OFS_W-1:0] cmt_base;
   logic [OFS_W-1:0] cmt_end;
   logic [OFS_W-1:0] done_ptr;
   logic [OFS_W-1:0] ring_mask;
   logic             unused_wdata;

   assign rd_sel       = rd_sel_e'(host_rd_sel);
   assign rst_dma      = host_wr_busctl && host_wdata[BUSCTL_RSTDMA_BIT];
   assign cnt_rd       = host_rd && (rd_sel == RD_FCOUNT);
   assign bufevt_rd    = host_rd && (rd_sel == RD_BUFEVT);
   assign unused_wdata = ^host_wdata;
   assign wr_data      = wd_data;

   rxring_wrptr #(
      .OFS_W(OFS_W), .LEN_W(LEN_W), .SMALL_AW(SMALL_AW),
      .ALIGN_B(ALIGN_B), .WORD_B(WORD_B)
   ) u_wrptr (
      .clk(clk), .rst_n(rst_n), .buf_large(buf_large), .rst_dma(rst_dma),
      .fr_start(fr_start), .wd_valid(wd_valid), .fr_end(fr_end), .fr_len(fr_len),
      .blocked(blocked), .cur_addr(wr_addr), .wr_en(wr_en), .drop_evt(drop_evt),
      .frame_done(frame_done), .sof_q(sof_offset), .done_ptr(done_ptr),
      .ring_mask(ring_mask)
   );

   rxring_commit #(.OFS_W(OFS_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .rst_dma(rst_dma), .cnt_rd(cnt_rd),
      .cnt_nonzero(cnt_nonzero), .skip_evt(skip_evt), .drop_evt(drop_evt),
      .done_ptr(done_ptr), .probe_addr(wr_addr), .blocked(blocked),
      .cmt_valid(cmt_valid), .cmt_base(cmt_base), .cmt_end(cmt_end),
      .overflow(overflow)
   );

   rxring_evt #(.CNT_W(CNT_W), .SAT_CNT(SAT_CNT)) u_evt (
      .clk(clk), .rst_n(rst_n), .rst_dma(rst_dma), .stream_mode(stream_mode),
      .strm_done(strm_done), .frame_done(frame_done), .cnt_rd(cnt_rd),
      .bufevt_rd(bufevt_rd), .cnt_q(frame_count), .pend_q(frame_pending),
      .cnt_nonzero(cnt_nonzero), .skip_evt(skip_evt)
   );

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         unique case (rd_sel)
            RD_FCOUNT: host_rdata = REG_W'(frame_count);
            RD_BUFEVT: host_rdata[BUFEVT_PEND_BIT] = frame_pending;
            default:   host_rdata = '0;
         endcase
      end
   end

   // R2: back-to-back writes advance by one word inside the ring
   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rst_dma) |=> (!wr_en || (wr_addr == (($past(wr_addr) + OFS_W'(WORD_B)) & ring_mask))));

   // R5: overflow rises only after a refused word
   assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> ($past(wd_valid) && !$past(wr_en)));

   // R8: reset-DMA clears the visible state one clock later
   assert_reset_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_dma |=> (frame_count == '0 && !frame_pending && !overflow &&
                   sof_offset == '0 && !cmt_valid && cmt_base == '0 && cmt_end == '0));

   // R11: receive-event reads return zero
   assert_rxevt_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rd_sel == RD_RXEVT) |-> (host_rdata == '0));

endmodule

// File: tb/rxring_commit_mgr_tb.sv
`timescale 1ns/1ps
module rxring_commit_mgr_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        buf_large = 1'b0;
   logic        stream_mode = 1'b0;
   logic        fr_start = 1'b0;
   logic        wd_valid = 1'b0;
   logic [15:0] wd_data = '0;
   logic        fr_end = 1'b0;
   logic [15:0] fr_len = '0;
   logic        strm_done = 1'b0;
   logic        host_rd = 1'b0;
   logic [1:0]  host_rd_sel = '0;
   logic [15:0] host_rdata;
   logic        host_wr_busctl = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [15:0] wr_data;
   logic [15:0] sof_offset;
   logic [15:0] frame_count;
   logic        frame_pending;
   logic        overflow;

   int n_chk  = 0;
   int n_fail = 0;
   int mask_m = 16'h3FFF;
   bit done_f = 1'b0;

   always #2.5 clk = ~clk;

   rxring_commit_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .buf_large(buf_large), .stream_mode(stream_mode),
      .fr_start(fr_start), .wd_valid(wd_valid), .wd_data(wd_data), .fr_end(fr_end),
      .fr_len(fr_len), .strm_done(strm_done), .host_rd(host_rd),
      .host_rd_sel(host_rd_sel), .host_rdata(host_rdata),
      .host_wr_busctl(host_wr_busctl), .host_wdata(host_wdata), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sof_offset(sof_offset),
      .frame_count(frame_count), .frame_pending(frame_pending), .overflow(overflow)
   );

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic send_frame(input int len, input int start, input int blk, input string req);
      bit refused = 1'b0;
      fr_start = 1'b1; step(); fr_start = 1'b0;
      for (int i = 0; i < (len + 1) / 2; i++) begin
         int ea;
         ea = (start + 2 * i) & mask_m;
         wd_valid = 1'b1;
         wd_data  = 16'(i) ^ 16'hA500;
         #1;
         if (blk >= 0 && ea == blk) refused = 1'b1;
         if (refused) chk(req, 48'(wr_en), 48'h0);
         else chk(req, {15'd0, wr_en, wr_addr, wr_data}, {15'd0, 1'b1, 16'(ea), 16'(i) ^ 16'hA500});
         step();
      end
      wd_valid = 1'b0;
      fr_end = 1'b1; fr_len = 16'(len); step(); fr_end = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] sel, output logic [15:0] val);
      host_rd = 1'b1; host_rd_sel = sel; #1;
      val = host_rdata;
      step(); host_rd = 1'b0; host_rd_sel = 2'd0;
   endtask

   task automatic busctl_write(input logic [15:0] d);
      host_wr_busctl = 1'b1; host_wdata = d; step();
      host_wr_busctl = 1'b0; host_wdata = '0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 count", 48'(frame_count), 48'h0);
      chk("R1 pending/overflow", {46'd0, frame_pending, overflow}, 48'h0);
      chk("R1 sof", 48'(sof_offset), 48'h0);
      chk("R1 wr_en", 48'(wr_en), 48'h0);
      host_read(2'd3, v);
      chk("R11 rx event reads zero", 48'(v), 48'h0);
   endtask

   task automatic t_basic();
      logic [15:0] v;
      send_frame(5, 0, -1, "R2 frame0 words");
      chk("R3 sof frame0", 48'(sof_offset), 48'd0);
      chk("R4 count after one", 48'(frame_count), 48'd1);
      chk("R9 pending rises", 48'(frame_pending), 48'd1);
      send_frame(7, 8, -1, "R3 frame1 after 3-byte hole");
      chk("R3 sof frame1", 48'(sof_offset), 48'd8);
      send_frame(6, 16, -1, "R3 frame2 after 1-byte hole");
      send_frame(4, 24, -1, "R3 frame3 after 2-byte hole");
      chk("R3 sof frame3", 48'(sof_offset), 48'd24);
      host_read(2'd2, v);
      chk("R11 buffer event bit7", 48'(v), 48'h80);
      chk("R9 pending kept by buffer-event read", 48'(frame_pending), 48'd1);
      host_read(2'd1, v);
      chk("R4 count read value", 48'(v), 48'd4);
      chk("R4 count cleared", 48'(frame_count), 48'd0);
      chk("R9 pending cleared at zero count", 48'(frame_pending), 48'd0);
   endtask

   task automatic t_commit_block();
      logic [15:0] v;
      busctl_write(16'h0040);
      send_frame(16000, 0, -1, "R2 big frame");
      host_read(2'd1, v);
      chk("R4 count read one", 48'(v), 48'd1);
      send_frame(1000, 16000, 0, "R5 write refused in committed span");
      chk("R5 overflow set", 48'(overflow), 48'd1);
      chk("R5 dropped frame not counted", 48'(frame_count), 48'd0);
      chk("R5 sof unchanged by drop", 48'(sof_offset), 48'd0);
      host_read(2'd1, v);
      chk("R6 empty reread value", 48'(v), 48'd0);
      send_frame(1000, 16000, -1, "R6 span released, wrap to 0 written");
      chk("R2 wrap end pointer via sof", 48'(sof_offset), 48'd16000);
      chk("R5 overflow stays set", 48'(overflow), 48'd1);
      busctl_write(16'h0020);
      chk("R8 bit6 clear leaves count", 48'(frame_count), 48'd1);
      chk("R8 bit6 clear leaves overflow", 48'(overflow), 48'd1);
      busctl_write(16'h0040);
      chk("R8 reset clears count/pending/ovf", {29'd0, frame_count, frame_pending, overflow}, 48'h0);
      chk("R8 reset clears sof", 48'(sof_offset), 48'd0);
      send_frame(4, 0, -1, "R8 pointer back at 0");
   endtask

   task automatic t_skip();
      logic [15:0] v;
      busctl_write(16'h0040);
      send_frame(16000, 0, -1, "R7 fill");
      host_read(2'd1, v);
      send_frame(200, 16000, -1, "R7 new frame after commit");
      chk("R7 pending before skip", 48'(frame_pending), 48'd1);
      host_read(2'd2, v);
      chk("R11 buffer event shows pending", 48'(v), 48'h80);
      chk("R9 pending after skip read", 48'(frame_pending), 48'd1);
      send_frame(400, 16200, -1, "R7 implied skip released span");
      chk("R7 no overflow", 48'(overflow), 48'd0);
      chk("R4 two frames counted", 48'(frame_count), 48'd2);
   endtask

   task automatic t_stream();
      logic [15:0] v;
      busctl_write(16'h0040);
      stream_mode = 1'b1;
      strm_done = 1'b1; step(); strm_done = 1'b0;
      chk("R10 strm_done with zero count", 48'(frame_pending), 48'd0);
      send_frame(4, 0, -1, "R10 stream frame");
      chk("R10 frame alone no pending", 48'(frame_pending), 48'd0);
      chk("R10 count one", 48'(frame_count), 48'd1);
      strm_done = 1'b1; step(); strm_done = 1'b0;
      chk("R10 pending after strm_done", 48'(frame_pending), 48'd1);
      host_read(2'd1, v);
      chk("R9 stream pending cleared at zero", 48'(frame_pending), 48'd0);
      stream_mode = 1'b0;
   endtask

   task automatic t_large();
      busctl_write(16'h0040);
      buf_large = 1'b1; mask_m = 16'hFFFF;
      send_frame(16000, 0, -1, "R2 large fill");
      send_frame(1000, 16000, -1, "R2 large ring passes 16384");
      chk("R3 large sof", 48'(sof_offset), 48'd16000);
      buf_large = 1'b0; mask_m = 16'h3FFF;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_commit_block();
      t_skip();
      t_stream();
      t_large();
      if (!done_f) begin
         done_f = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_f) begin
         done_f = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule